// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Register

This block turns a serial bit stream into a parallel word in two stages. A chain of W one-bit stages takes one new bit from the serial input on every rising edge of a shift clock. A separate holding register copies the whole chain on a rising edge of its own store clock. Because of this split, the parallel outputs stay steady while the next word is being shifted in. They change only when the store clock fires.

The last stage of the chain is always visible on a serial output, so several blocks can be chained end to end to form longer words. The parallel outputs go through tri-state drivers with an active-low enable. An active-low asynchronous clear empties the chain without touching the holding register. A clear followed by a store pulse is therefore the way to force the parallel outputs to zero.

Top module: `sipo_latch`

## Requirements
- R1: On a rising edge of `shift_clk` while `clr_n` is high, stage 0 takes `ser_in` and each stage n takes the old value of stage n-1. After W shifts, the bit that entered first sits in stage W-1.
- R2: On a rising edge of `store_clk`, every bit of the holding register takes the matching shift stage. A store does not alter the shift stages.
- R3: `ser_out` always equals stage W-1, so after a shift it shows the previous value of stage W-2. `ser_out` is driven whatever the level of `oe_n`.
- R4: When `clr_n` is low, every shift stage and `ser_out` go to 0 at once, with no clock needed. Shift edges have no effect while the clear is held.
- R5: `clr_n` leaves the holding register unchanged. A clear followed by a `store_clk` edge drives zeros onto `par_q`.
- R6: With `oe_n` high, every bit of `par_q` is high impedance. With `oe_n` low, `par_q` shows the holding register.
- R7: When both clocks rise on the same edge, the holding register takes the chain contents from before that edge, one shift behind the chain.
- R8: `par_q[n]` carries stage n. For example, a single 1 followed by two 0s gives `par_q` = 8'h04 after a store, with W = 8.
- R9: When the `ser_out` of one block feeds the `ser_in` of a second block on the same clocks, the second block receives the bits that leave the first block's stage W-1, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_clk | input | 1 | Clock for the shift chain, active on the rising edge |
| store_clk | input | 1 | Clock for the holding register, active on the rising edge |
| clr_n | input | 1 | Asynchronous clear of the shift chain, active low |
| oe_n | input | 1 | Enable for the parallel drivers, active low |
| ser_in | input | 1 | Serial data into stage 0 |
| ser_out | output | 1 | Serial cascade output taken from stage W-1 |
| par_q | output | W | Parallel outputs from the holding register, tri-state |

## Verification
The hardest cases are the ones where the two clock domains and the clear interact. The first is a store edge that lands on exactly the same edge as a shift, where the holding register must take the old chain. The second is a clear that arrives between shift edges while a word is only partly shifted in. The bench drives both clocks from a single statement, so the coincident edge really does occur in one time step. It also drops `clr_n` in the middle of a random shift run and holds it across a shift edge. The bench reads high impedance by pulling one instance's parallel net high and the other's low. A floating bus then reads as a value the holding register does not contain at that point.

// File: rtl/sipo_latch_pkg.sv
package sipo_latch_pkg;

    localparam int unsigned SIPO_WIDTH = 8;

    // Drive state of the parallel output drivers.
    typedef enum logic {
        PAR_DRIVE = 1'b0,
        PAR_FLOAT = 1'b1
    } par_mode_e;

    function automatic par_mode_e par_mode(input logic oe_n);
        return oe_n ? PAR_FLOAT : PAR_DRIVE;
    endfunction

endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
    parameter int unsigned W = 8
) (
    input  logic         shift_clk,
    input  logic         clr_n,
    input  logic         ser_in,
    output logic [W-1:0] stages
);
    localparam int unsigned TOP = W - 1;

    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n) stages <= '0;
        else        stages <= {stages[TOP-1:0], ser_in};
    end

    // Counts shift edges since the clear was last released, saturating at 2.
    // Assertions use it so that $past never looks back across a clear.
    logic [1:0] edge_cnt;
    always_ff @(posedge shift_clk or negedge clr_n) begin
        if (!clr_n)               edge_cnt <= 2'd0;
        else if (edge_cnt != 2'd2) edge_cnt <= edge_cnt + 2'd1;
    end

    // R1: the new bit enters at stage 0
    a_r1_stage0_takes_input: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (edge_cnt != 2'd0) |-> (stages[0] == $past(ser_in)));

    // R3: the upper stages, the cascade stage included, hold the old lower ones
    a_r3_chain_moves_up: assert property (@(posedge shift_clk) disable iff (!clr_n)
        (edge_cnt != 2'd0) |-> (stages[TOP:1] == $past(stages[TOP-1:0])));

    // R4: while the clear is held, the chain reads empty at every shift edge
    always @(posedge shift_clk) begin
        if (!clr_n) begin
            a_r4_clear_empties: assert (stages == '0);
        end
    end

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         store_clk,
    input  logic         clr_n,
    input  logic [W-1:0] snap,
    output logic [W-1:0] hold_q
);
    // No reset: the holding register keeps its value through a chain clear.
    always_ff @(posedge store_clk) begin
        hold_q <= snap;
    end

    // Checker state, cleared by clr_n only so that it never looks back past a clear.
    logic         seen;
    logic [W-1:0] prev_snap;
    always_ff @(posedge store_clk or negedge clr_n) begin
        if (!clr_n) begin
            seen      <= 1'b0;
            prev_snap <= '0;
        end else begin
            seen      <= 1'b1;
            prev_snap <= snap;
        end
    end

    // R2 / R7: each store edge shows the chain value sampled at the previous store edge
    always @(posedge store_clk) begin
        if (clr_n && seen) begin
            a_r2_capture_chain: assert (hold_q == prev_snap);
        end
    end

endmodule

// File: rtl/sipo_latch.sv
module sipo_latch
    import sipo_latch_pkg::*;
#(
    parameter int unsigned W = SIPO_WIDTH
) (
    input  logic         shift_clk,
    input  logic         store_clk,
    input  logic         clr_n,
    input  logic         oe_n,
    input  logic         ser_in,
    output logic         ser_out,
    output logic [W-1:0] par_q
);
    localparam int unsigned TOP = W - 1;

    logic [W-1:0] chain;
    logic [W-1:0] hold_q;
    par_mode_e    mode;

    sipo_shift_chain #(.W(W)) u_chain (
        .shift_clk (shift_clk),
        .clr_n     (clr_n),
        .ser_in    (ser_in),
        .stages    (chain)
    );

    sipo_hold_reg #(.W(W)) u_hold (
        .store_clk (store_clk),
        .clr_n     (clr_n),
        .snap      (chain),
        .hold_q    (hold_q)
    );

    assign ser_out = chain[TOP];
    assign mode    = par_mode(oe_n);
    assign par_q   = (mode == PAR_FLOAT) ? {W{1'bz}} : hold_q;

endmodule

// File: tb/sipo_latch_test.sv
module sipo_latch_test;
    localparam int PERIOD = 10;
    localparam int W = 8;

    logic shift_clk = 1'b0;
    logic store_clk = 1'b0;
    logic clr_n = 1'b0;
    logic oe_n = 1'b1;
    logic din = 1'b0;
    wire link;
    wire tail;
    tri1 [W-1:0] bus_a;
    tri0 [W-1:0] bus_b;

    sipo_latch #(.W(W)) uut (
        .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .ser_in(din), .ser_out(link), .par_q(bus_a)
    );
    sipo_latch #(.W(W)) uut_b (
        .shift_clk(shift_clk), .store_clk(store_clk), .clr_n(clr_n), .oe_n(oe_n),
        .ser_in(link), .ser_out(tail), .par_q(bus_b)
    );

    logic [W-1:0] m_sa = '0, m_sb = '0, m_ha = '0, m_hb = '0;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    function automatic logic [W-1:0] exp_bus(input logic [W-1:0] h, input logic oe, input logic pull);
        return oe ? {W{pull}} : h;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input bit sh, input bit st, input bit d);
        din = d;
        #(PERIOD/2);
        if (st) begin m_ha = m_sa; m_hb = m_sb; end
        if (sh && clr_n) begin
            m_sb = {m_sb[W-2:0], m_sa[W-1]};
            m_sa = {m_sa[W-2:0], d};
        end
        shift_clk = sh;
        store_clk = st;
        #(PERIOD/2);
        shift_clk = 1'b0;
        store_clk = 1'b0;
    endtask

    task automatic check_all(input string tag);
        check({tag, " R3 ser_out a"}, W'(link), W'(m_sa[W-1]));
        check({tag, " R9 ser_out b"}, W'(tail), W'(m_sb[W-1]));
        check({tag, " R6 bus a"}, bus_a, exp_bus(m_ha, oe_n, 1'b1));
        check({tag, " R6 bus b"}, bus_b, exp_bus(m_hb, oe_n, 1'b0));
    endtask

    task automatic shift_byte(input logic [W-1:0] v);
        for (int i = W - 1; i >= 0; i--) tick(1'b1, 1'b0, v[i]);
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        // reset state
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b0, 1'b0, 1'b0);
        #1;
        check("R4 reset ser_out a", W'(link), '0);
        check("R4 reset ser_out b", W'(tail), '0);
        clr_n = 1'b1;
        tick(1'b0, 1'b1, 1'b0);
        oe_n = 1'b0; #1;
        check("R5 store after clear", bus_a, 8'h00);
        oe_n = 1'b1; #1;
        check("R6 float pulls high", bus_a, 8'hFF);
        check("R6 float pulls low", bus_b, 8'h00);
        oe_n = 1'b0;
        // bit mapping
        tick(1'b1, 1'b0, 1'b1);
        tick(1'b1, 1'b0, 1'b0);
        tick(1'b1, 1'b0, 1'b0);
        check("R2 no change before store", bus_a, 8'h00);
        tick(1'b0, 1'b1, 1'b0);
        check("R8 mapping", bus_a, 8'h04);
        // full word, then cascade
        shift_byte(8'hA5);
        check("R1 chain msb", W'(link), W'(1'b1));
        tick(1'b0, 1'b1, 1'b0);
        check("R1 word stored", bus_a, 8'hA5);
        check("R9 cascade word", bus_b, 8'h04);
        // coincident edges
        tick(1'b1, 1'b1, 1'b1);
        check("R7 same edge takes old chain", bus_a, 8'hA5);
        tick(1'b0, 1'b1, 1'b0);
        check("R7 next store shows new chain", bus_a, 8'h4B);
        // clear while shifting
        tick(1'b1, 1'b0, 1'b1);
        #1 clr_n = 1'b0;
        m_sa = '0; m_sb = '0;
        #1;
        check("R4 clear is immediate", W'(link), '0);
        check("R5 clear keeps holding a", bus_a, 8'h4B);
        tick(1'b1, 1'b0, 1'b1);
        check("R4 shift ignored in clear", W'(link), '0);
        clr_n = 1'b1;
        tick(1'b0, 1'b1, 1'b0);
        check("R5 clear then store", bus_a, 8'h00);
        // serial output with drivers off
        oe_n = 1'b1;
        shift_byte(8'h80);
        check("R3 ser_out with oe_n high", W'(link), W'(1'b1));
        check_all("directed");
        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [3:0] r;
            r = 4'($urandom);
            if (r == 4'd0) oe_n = ~oe_n;
            if (r == 4'd1) begin
                tick(1'b1, 1'b0, 1'b1);
                #1 clr_n = 1'b0;
                m_sa = '0; m_sb = '0;
                #1 check("R4 random clear", W'(link), '0);
                tick(1'b1, 1'($urandom), 1'($urandom));
                clr_n = 1'b1;
            end
            tick(r[2] | r[3], r[1] & r[3], 1'($urandom));
            check_all("random");
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule